// File: doc/BRIEF.md
# Firmware Image Integrity Checker

This block decides whether a firmware image held in an external memory is well formed before anything downstream is allowed to use it. After a start pulse it fetches the image one 32-bit dword per clock over a plain read port. The read port is combinational: the memory returns the dword for the presented address in the same cycle. From the header it works out the data and total sizes. It then checks the layout of the optional trailing signature table, verifies the zero-sum checksums, and confirms that every table entry agrees with the primary signature triple.

All sums are 32-bit wraparound sums. The header plus data region must sum to zero, the trailing table must sum to zero on its own, and each table entry (signature, platform mask, checksum) must add up to the same value as the primary triple stored in the header. The checks run in a fixed order and the first one that fails is reported through a 3-bit reason code. Choosing between several images and applying an image are left to other logic.

Top module: `fw_image_checker`

## Requirements
- R1: After reset, `done_o`, `valid_o`, `reason_o` and `rd_en_o` are all 0.
- R2: Header dwords sit at fixed positions: header version at dword 0, signature at 3, checksum at 4, loader version at 5, platform mask at 6, data size at 7 and total size at 8 (sizes in bytes; the header is 48 bytes). A data-size field of zero selects 2000 data bytes and a 2048-byte total, and the total-size field is then ignored.
- R3: When data size plus 48 exceeds total size, or when total size exceeds 4·2^ADDR_W bytes, the result is a failure with reason 1.
- R4: When the loader-version field is not 1, or the header-version field differs from `exp_type_i`, the result is a failure with reason 2.
- R5: The table size is the total size minus 48 minus the data size. When it is nonzero and either below 20 bytes or not 20 plus a multiple of 12, the result is a failure with reason 3.
- R6: The first dword of the table holds the entry count. A nonzero table size that differs from count·12 + 20 (computed without overflow) gives a failure with reason 4.
- R7: When the wraparound sum of all table dwords is not zero, the result is a failure with reason 5.
- R8: When the wraparound sum of all header and data dwords is not zero, the result is a failure with reason 6.
- R9: Entries start at table dword 5, three dwords each (signature, mask, checksum). When the primary signature plus mask plus checksum, minus an entry's three dwords, is not zero, the result is a failure with reason 7.
- R10: When every check passes, `valid_o` is 1 and `reason_o` is 0. With no table, the image is valid as soon as the header and data sum passes.
- R11: Checks run in reason-code order (1 to 7) and the first failing one is reported.
- R12: A start accepted while idle or done clears `done_o` in the next cycle, and reading then begins at address 0. `done_o`, `valid_o` and `reason_o` hold steady until the next start, and no reads are issued while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin checking the image (single-cycle pulse) |
| exp_type_i | input | 32 | Header-version value the image must carry |
| rd_en_o | output | 1 | Read request for the current address |
| rd_addr_o | output | ADDR_W | Dword address into the image |
| rd_data_i | input | 32 | Dword at `rd_addr_o`, valid in the same cycle |
| done_o | output | 1 | Verdict available |
| valid_o | output | 1 | Image passed every check |
| reason_o | output | 3 | Failure reason, 0 when valid |

## Verification
The images are built in the bench from the header rules. The bench varies the size fields in several ways: aligned sizes, the default-size encoding combined with a total-size field that would be illegal, an oversize total, and tables that are too short or misaligned. These cases separate the size, format and truncation paths. Other images are good except for exactly one corrupted sum: the main region, the table, or the first or last table entry. Each of these isolates a single checksum path. Further images carry two faults at once, which shows that the earlier check in the order wins. Tables with zero entries and a huge count field cover the empty-loop and overflow boundaries.

// File: rtl/fwchk_pkg.sv
package fwchk_pkg;

  // Reason codes; numeric order is the check order
  typedef enum logic [2:0] {
    RSN_NONE   = 3'd0,
    RSN_SIZE   = 3'd1,
    RSN_FORMAT = 3'd2,
    RSN_TRUNC  = 3'd3,
    RSN_COUNT  = 3'd4,
    RSN_XSUM   = 3'd5,
    RSN_MSUM   = 3'd6,
    RSN_ENTRY  = 3'd7
  } reason_e;

  localparam int unsigned HDR_BYTES     = 48;
  localparam int unsigned TBL_HDR_BYTES = 20;
  localparam int unsigned ENTRY_BYTES   = 12;
  localparam int unsigned TBL_HDR_DW    = TBL_HDR_BYTES / 4;
  localparam int unsigned ENTRY_DW      = ENTRY_BYTES / 4;

  // dword positions inside the header
  localparam int unsigned POS_HVER  = 0;
  localparam int unsigned POS_SIG   = 3;
  localparam int unsigned POS_CKSUM = 4;
  localparam int unsigned POS_LVER  = 5;
  localparam int unsigned POS_PF    = 6;
  localparam int unsigned POS_DSZ   = 7;
  localparam int unsigned POS_TSZ   = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_EVAL, ST_CNT, ST_XSUM, ST_MSUM, ST_ENT, ST_DONE
  } state_e;

  // table length implied by an entry count, kept wide so it cannot wrap
  function automatic logic [35:0] table_bytes(input logic [31:0] count);
    return ({4'd0, count} * 36'd12) + 36'd20;
  endfunction

  // wraparound sum of one signature triple
  function automatic logic [31:0] triple_sum(input logic [31:0] a,
                                             input logic [31:0] b,
                                             input logic [31:0] c);
    return a + b + c;
  endfunction

  // remainder of the entry region length after removing the table header
  function automatic logic [31:0] entry_rem(input logic [31:0] tbl_bytes);
    return (tbl_bytes - 32'(TBL_HDR_BYTES)) % 32'(ENTRY_BYTES);
  endfunction

endpackage

// File: rtl/fwchk_field_eval.sv
module fwchk_field_eval
  import fwchk_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int DEF_DATA_BYTES = 2000
) (
  input  logic [31:0]       hver_i,
  input  logic [31:0]       lver_i,
  input  logic [31:0]       dsz_i,
  input  logic [31:0]       tsz_i,
  input  logic [31:0]       exp_type_i,
  output logic              size_bad_o,
  output logic              fmt_bad_o,
  output logic              trunc_bad_o,
  output logic              tbl_present_o,
  output logic [31:0]       tbl_bytes_o,
  output logic [ADDR_W-1:0] main_last_o,
  output logic [ADDR_W-1:0] tbl_base_o,
  output logic [ADDR_W-1:0] tbl_last_o
);

  localparam logic [32:0] MAX_BYTES = 33'(4) << ADDR_W;
  localparam logic [31:0] DEF_TOTAL = 32'(DEF_DATA_BYTES + HDR_BYTES);

  logic [31:0] data_b;
  logic [31:0] total_b;
  logic [32:0] need_b;

  always_comb begin
    data_b  = (dsz_i == 32'd0) ? 32'(DEF_DATA_BYTES) : dsz_i;
    total_b = (dsz_i == 32'd0) ? DEF_TOTAL : tsz_i;
    need_b  = {1'b0, data_b} + 33'(HDR_BYTES);
  end

  assign size_bad_o    = (need_b > {1'b0, total_b}) || ({1'b0, total_b} > MAX_BYTES);
  assign fmt_bad_o     = (lver_i != 32'd1) || (hver_i != exp_type_i);
  assign tbl_bytes_o   = total_b - data_b - 32'(HDR_BYTES);
  assign tbl_present_o = (tbl_bytes_o != 32'd0);
  assign trunc_bad_o   = tbl_present_o &&
                         ((tbl_bytes_o < 32'(TBL_HDR_BYTES)) || (entry_rem(tbl_bytes_o) != 32'd0));

  assign tbl_base_o  = ADDR_W'((data_b + 32'(HDR_BYTES)) >> 2);
  assign main_last_o = tbl_base_o - ADDR_W'(1);
  assign tbl_last_o  = tbl_base_o + ADDR_W'(tbl_bytes_o >> 2) - ADDR_W'(1);

endmodule

// File: rtl/fwchk_word_sum.sv
module fwchk_word_sum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         add_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] acc_next_o
);

  assign acc_next_o = acc_o + din_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_o <= '0;
    else if (clr_i)  acc_o <= '0;
    else if (add_i)  acc_o <= acc_next_o;
  end

endmodule

// File: rtl/fw_image_checker.sv
module fw_image_checker
  import fwchk_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int DEF_DATA_BYTES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       exp_type_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [31:0]       rd_data_i,
  output logic              done_o,
  output logic              valid_o,
  output logic [2:0]        reason_o
);

  localparam logic [ADDR_W-1:0] HDR_LAST = ADDR_W'(POS_TSZ);

  state_e            state, state_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic [1:0]        phase, phase_n;
  logic [31:0]       hver_q, sig_q, cks_q, lver_q, pf_q, dsz_q, tsz_q, exp_q, cnt_q;

  logic              size_bad, fmt_bad, trunc_bad, tbl_present;
  logic [31:0]       tbl_bytes;
  logic [ADDR_W-1:0] main_last, tbl_base, tbl_last;

  logic              sum_clr, sum_add, trip_clr, trip_add;
  logic [31:0]       sum_acc, sum_next, trip_acc, trip_next;

  // named events for the checker
  logic              launch;
  logic              fin_evt;
  reason_e           fin_code;

  fwchk_field_eval #(.ADDR_W(ADDR_W), .DEF_DATA_BYTES(DEF_DATA_BYTES)) u_eval (
    .hver_i        (hver_q),
    .lver_i        (lver_q),
    .dsz_i         (dsz_q),
    .tsz_i         (tsz_q),
    .exp_type_i    (exp_q),
    .size_bad_o    (size_bad),
    .fmt_bad_o     (fmt_bad),
    .trunc_bad_o   (trunc_bad),
    .tbl_present_o (tbl_present),
    .tbl_bytes_o   (tbl_bytes),
    .main_last_o   (main_last),
    .tbl_base_o    (tbl_base),
    .tbl_last_o    (tbl_last)
  );

  fwchk_word_sum #(.W(32)) u_region_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (sum_clr),
    .add_i      (sum_add),
    .din_i      (rd_data_i),
    .acc_o      (sum_acc),
    .acc_next_o (sum_next)
  );

  fwchk_word_sum #(.W(32)) u_triple_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (trip_clr),
    .add_i      (trip_add),
    .din_i      (rd_data_i),
    .acc_o      (trip_acc),
    .acc_next_o (trip_next)
  );

  assign launch    = start_i && ((state == ST_IDLE) || (state == ST_DONE));
  assign rd_en_o   = (state == ST_HDR) || (state == ST_CNT) || (state == ST_XSUM) ||
                     (state == ST_MSUM) || (state == ST_ENT);
  assign rd_addr_o = addr;

  always_comb begin
    state_n  = state;
    addr_n   = addr;
    phase_n  = phase;
    sum_clr  = 1'b0;
    sum_add  = 1'b0;
    trip_clr = 1'b0;
    trip_add = 1'b0;
    fin_evt  = 1'b0;
    fin_code = RSN_NONE;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_n = ST_HDR;
          addr_n  = '0;
        end
      end
      ST_HDR: begin
        if (addr == HDR_LAST) state_n = ST_EVAL;
        else                  addr_n  = addr + ADDR_W'(1);
      end
      ST_EVAL: begin
        if (size_bad) begin
          fin_evt = 1'b1; fin_code = RSN_SIZE;
        end else if (fmt_bad) begin
          fin_evt = 1'b1; fin_code = RSN_FORMAT;
        end else if (tbl_present) begin
          if (trunc_bad) begin
            fin_evt = 1'b1; fin_code = RSN_TRUNC;
          end else begin
            addr_n  = tbl_base;
            state_n = ST_CNT;
          end
        end else begin
          addr_n  = '0;
          sum_clr = 1'b1;
          state_n = ST_MSUM;
        end
      end
      ST_CNT: begin
        if (table_bytes(rd_data_i) != {4'd0, tbl_bytes}) begin
          fin_evt = 1'b1; fin_code = RSN_COUNT;
        end else begin
          sum_clr = 1'b1;
          state_n = ST_XSUM;
        end
      end
      ST_XSUM: begin
        sum_add = 1'b1;
        if (addr == tbl_last) begin
          if (sum_next != 32'd0) begin
            fin_evt = 1'b1; fin_code = RSN_XSUM;
          end else begin
            sum_clr = 1'b1;
            addr_n  = '0;
            state_n = ST_MSUM;
          end
        end else begin
          addr_n = addr + ADDR_W'(1);
        end
      end
      ST_MSUM: begin
        sum_add = 1'b1;
        if (addr == main_last) begin
          if (sum_next != 32'd0) begin
            fin_evt = 1'b1; fin_code = RSN_MSUM;
          end else if (tbl_present && (cnt_q != 32'd0)) begin
            addr_n   = tbl_base + ADDR_W'(TBL_HDR_DW);
            trip_clr = 1'b1;
            phase_n  = '0;
            state_n  = ST_ENT;
          end else begin
            fin_evt = 1'b1; fin_code = RSN_NONE;
          end
        end else begin
          addr_n = addr + ADDR_W'(1);
        end
      end
      ST_ENT: begin
        trip_add = 1'b1;
        if (phase == 2'(ENTRY_DW - 1)) begin
          if (triple_sum(sig_q, pf_q, cks_q) - trip_next != 32'd0) begin
            fin_evt = 1'b1; fin_code = RSN_ENTRY;
          end else if (addr == tbl_last) begin
            fin_evt = 1'b1; fin_code = RSN_NONE;
          end else begin
            trip_clr = 1'b1;
            phase_n  = '0;
            addr_n   = addr + ADDR_W'(1);
          end
        end else begin
          phase_n = phase + 2'd1;
          addr_n  = addr + ADDR_W'(1);
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (fin_evt) state_n = ST_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr     <= '0;
      phase    <= '0;
      done_o   <= 1'b0;
      valid_o  <= 1'b0;
      reason_o <= 3'd0;
      exp_q    <= '0;
      cnt_q    <= '0;
    end else begin
      state <= state_n;
      addr  <= addr_n;
      phase <= phase_n;
      if (launch) begin
        done_o   <= 1'b0;
        valid_o  <= 1'b0;
        reason_o <= 3'd0;
        exp_q    <= exp_type_i;
      end else if (fin_evt) begin
        done_o   <= 1'b1;
        valid_o  <= (fin_code == RSN_NONE);
        reason_o <= fin_code;
      end
      if (state == ST_CNT) cnt_q <= rd_data_i;
    end
  end

  // header field capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hver_q <= '0; sig_q <= '0; cks_q <= '0; lver_q <= '0;
      pf_q   <= '0; dsz_q <= '0; tsz_q <= '0;
    end else if (state == ST_HDR) begin
      if (addr == ADDR_W'(POS_HVER))  hver_q <= rd_data_i;
      if (addr == ADDR_W'(POS_SIG))   sig_q  <= rd_data_i;
      if (addr == ADDR_W'(POS_CKSUM)) cks_q  <= rd_data_i;
      if (addr == ADDR_W'(POS_LVER))  lver_q <= rd_data_i;
      if (addr == ADDR_W'(POS_PF))    pf_q   <= rd_data_i;
      if (addr == ADDR_W'(POS_DSZ))   dsz_q  <= rd_data_i;
      if (addr == ADDR_W'(POS_TSZ))   tsz_q  <= rd_data_i;
    end
  end

endmodule

// File: rtl/fw_image_checker_sva.sv
module fw_image_checker_sva #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              launch,
  input logic              fin_evt,
  input logic [2:0]        fin_code,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              done_o,
  input logic              valid_o,
  input logic [2:0]        reason_o
);

  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(reason_o) && $stable(valid_o)));

  // R12
  launch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (!done_o && rd_en_o && (rd_addr_o == '0)));

  // R12
  no_read_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_en_o);

  // R10
  valid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (done_o && (reason_o == 3'd0)));

  // R11
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !valid_o) |-> (reason_o != 3'd0));

  // R11
  verdict_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (done_o && (reason_o == $past(fin_code))));

endmodule

bind fw_image_checker fw_image_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .launch    (launch),
  .fin_evt   (fin_evt),
  .fin_code  (fin_code),
  .rd_en_o   (rd_en_o),
  .rd_addr_o (rd_addr_o),
  .done_o    (done_o),
  .valid_o   (valid_o),
  .reason_o  (reason_o)
);

// File: tb/test_fw_image_checker.sv
module test_fw_image_checker;

  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] SIG = 32'h000A_0671;
  localparam logic [31:0] PF  = 32'h0000_0022;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   exp_type = 32'd1;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic          done, valid;
  logic [2:0]    reason;

  logic [31:0] img [0:DEPTH-1];

  int n_chk = 0;
  int n_fail = 0;
  int seen = 0;
  bit finished = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  assign rd_data = img[rd_addr];

  fw_image_checker #(.ADDR_W(AW), .DEF_DATA_BYTES(2000)) i_fw_image_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .exp_type_i (exp_type),
    .rd_en_o    (rd_en),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .done_o     (done),
    .valid_o    (valid),
    .reason_o   (reason)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Builds an image in the memory model following R2, R5, R6, R9
  task automatic build(input logic [31:0] dsz_f, input logic [31:0] tsz_f,
                       input logic [31:0] hv, input logic [31:0] lv,
                       input int n_ent, input logic [31:0] cnt_f,
                       input bit bad_main, input bit bad_tbl, input int bad_ent);
    int data_b, tot_b, base, tdw;
    logic [31:0] s, p, es, ep;
    for (int i = 0; i < DEPTH; i++) img[i] = 32'd0;
    img[0] = hv; img[1] = 32'h0000_0042; img[2] = 32'h0315_2024;
    img[3] = SIG; img[5] = lv; img[6] = PF; img[7] = dsz_f; img[8] = tsz_f;
    data_b = (dsz_f == 0) ? 2000 : int'(dsz_f);
    tot_b  = (dsz_f == 0) ? 2048 : int'(tsz_f);
    if (48 + data_b <= 4 * DEPTH) begin
      for (int i = 12; i < 12 + data_b / 4; i++) img[i] = (i * 32'h9E37_79B9) ^ 32'h55;
      s = 32'd0;
      for (int i = 0; i < (48 + data_b) / 4; i++) s += img[i];
      img[4] = -s + (bad_main ? 32'd1 : 32'd0);
    end
    p = img[3] + img[6] + img[4];
    if (n_ent >= 0 && tot_b > 48 + data_b && tot_b <= 4 * DEPTH) begin
      base = (48 + data_b) / 4;
      tdw  = (tot_b - 48 - data_b) / 4;
      img[base] = cnt_f;
      for (int e = 0; e < n_ent; e++) begin
        es = SIG + 32'(e) + 32'd1;
        ep = 32'd1 << e;
        img[base + 5 + 3 * e]     = es;
        img[base + 5 + 3 * e + 1] = ep;
        img[base + 5 + 3 * e + 2] = p - es - ep + ((e == bad_ent) ? 32'd7 : 32'd0);
      end
      s = 32'd0;
      for (int i = base; i < base + tdw; i++) s += img[i];
      img[base + 1] = -s + (bad_tbl ? 32'd1 : 32'd0);
    end
  endtask

  // Driver: queue the expected verdict, pulse start, wait for the monitor
  task automatic run_case(input string tag, input logic [2:0] expr);
    int target;
    exp_q.push_back(expr);
    tag_q.push_back(tag);
    target = seen + 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check({"R12 done cleared after start: ", tag}, {31'd0, done}, 32'd0);
    check({"R12 read from address 0: ", tag}, {31'd0, rd_en} | (32'(rd_addr) << 1), 32'd1);
    wait (seen == target);
    repeat (3) @(negedge clk);
    check({"R12 verdict held: ", tag}, {28'd0, done, reason}, {28'd1, expr});
  endtask

  // Monitor: compare each new verdict with the scoreboard head
  initial begin
    logic done_prev;
    logic [2:0] r;
    string t;
    done_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (done && !done_prev) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R12 unexpected verdict actual=%0d expected=none", reason);
        end else begin
          r = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " reason"}, {29'd0, reason}, {29'd0, r});
          check({t, " valid"}, {31'd0, valid}, {31'd0, (r == 3'd0)});
        end
        seen++;
      end
      done_prev = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) img[i] = 32'd0;
    repeat (3) @(negedge clk);
    check("R1 done after reset", {31'd0, done}, 32'd0);
    check("R1 valid after reset", {31'd0, valid}, 32'd0);
    check("R1 reason after reset", {29'd0, reason}, 32'd0);
    check("R1 rd_en after reset", {31'd0, rd_en}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    build(16, 64, 1, 1, -1, 0, 0, 0, -1);    run_case("R10 plain image", 3'd0);
    build(16, 64, 1, 1, -1, 0, 1, 0, -1);    run_case("R8 main sum off", 3'd6);
    build(100, 64, 1, 1, -1, 0, 0, 0, -1);   run_case("R3 data beyond total", 3'd1);
    build(16, 8192, 1, 1, -1, 0, 0, 0, -1);  run_case("R3 total too large", 3'd1);
    build(16, 64, 1, 2, -1, 0, 0, 0, -1);    run_case("R4 loader version", 3'd2);
    build(16, 64, 3, 1, -1, 0, 0, 0, -1);    run_case("R4 header type", 3'd2);
    exp_type = 32'd5;
    build(16, 64, 5, 1, -1, 0, 0, 0, -1);    run_case("R4 type from input", 3'd0);
    exp_type = 32'd1;
    build(16, 80, 1, 1, -1, 0, 0, 0, -1);    run_case("R5 table 16 bytes", 3'd3);
    build(16, 88, 1, 1, -1, 0, 0, 0, -1);    run_case("R5 table 24 bytes", 3'd3);
    build(16, 108, 1, 1, 2, 2, 0, 0, -1);    run_case("R10 two entries", 3'd0);
    build(16, 108, 1, 1, 2, 3, 0, 0, -1);    run_case("R6 count mismatch", 3'd4);
    build(16, 84, 1, 1, 0, 32'h4000_0000, 0, 0, -1); run_case("R6 huge count", 3'd4);
    build(16, 84, 1, 1, 0, 0, 0, 0, -1);     run_case("R10 empty table", 3'd0);
    build(16, 108, 1, 1, 2, 2, 0, 1, -1);    run_case("R7 table sum off", 3'd5);
    build(16, 108, 1, 1, 2, 2, 0, 0, 0);     run_case("R9 first entry", 3'd7);
    build(16, 108, 1, 1, 2, 2, 0, 0, 1);     run_case("R9 last entry", 3'd7);
    build(100, 64, 1, 2, -1, 0, 0, 0, -1);   run_case("R11 size before format", 3'd1);
    build(16, 108, 1, 1, 2, 2, 1, 1, -1);    run_case("R11 table before main", 3'd5);
    build(16, 108, 1, 1, 2, 2, 1, 0, 1);     run_case("R11 main before entry", 3'd6);
    build(0, 12345, 1, 1, -1, 0, 0, 0, -1);  run_case("R2 default sizes", 3'd0);
    build(0, 12345, 1, 1, -1, 0, 1, 0, -1);  run_case("R2 default sum off", 3'd6);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule